// File: doc/BRIEF.md
# Memory protection region matcher with attribute decoding

This block holds a small table of programmable protection regions and classifies every memory access against it. Each region has an aligned base address, a power-of-two size code, an enable bit and an attribute word. The attribute word holds the memory-type bits, the access-rights code and the execute-never bit. Software fills the table through a single register-write port. A control register selects which region the base, size and attribute writes go to.

For each access the block reports several results in the same cycle, with no register on the lookup path: whether an enabled region matched, which region won, the decoded memory type, the shareability, and the inner and outer cache policy codes. It also raises a permission fault when the rights code, the execute-never bit or a miss forbids the access. When regions overlap, the highest-numbered matching region wins. A privileged access that misses every region may fall back to a default map, if the control register allows it.

Top module: `mpu_region_match`

## Requirements
- R1: After reset every region is disabled, the selected region is 0 and the fallback is off. Every access then reports hit=0, hit_region=0, mem_type=10 (normal), shareable=0, both policies 00 and fault=1.
- R2: An enabled region with size code S (4 to 31) matches when the access address and the base agree on every bit from S+1 upward. The region therefore covers 2^(S+1) bytes on a matching boundary, and code 31 matches every address.
- R3: A size code below 4 behaves as code 4, giving a 32-byte region. Base bits 4:0 are dropped when the base is written.
- R4: A write with cfg_sel=00 loads the selected region number from wdata[2:0] and the fallback enable from wdata[31]. The other selects act only on the selected region. cfg_sel=01 loads the base from wdata[31:5]. cfg_sel=10 loads the enable from wdata[0] and the size code from wdata[5:1]. cfg_sel=11 loads the attribute word: wdata[0]=B, [1]=C, [2]=S, [5:3]=TEX, [8:6]=AP, [9]=XN. A write takes effect on the next lookup after the clock edge.
- R5: Disabled regions never match. Among matching enabled regions the highest-numbered one sets hit_region and the attributes.
- R6: mem_type is coded 00 strongly-ordered, 01 device, 10 normal, 11 unsupported. TEX=000, C=0 gives strongly-ordered when B=0 and device when B=1. Both are shareable whatever S holds, and both have policies 00.
- R7: TEX=000, C=1 gives normal memory with shareable=S. The policy codes are 00 non-cacheable, 01 write-back with read/write allocate, 10 write-through without write allocate, and 11 write-back without write allocate. B=0 sets both inner and outer policy to 10, and B=1 sets both to 11.
- R8: TEX=001 with C,B=00 gives normal non-cacheable memory (policies 00, shareable=S). TEX=001 with C,B=11 gives normal memory with both policies 01 and shareable=S. TEX=001 with C,B=01 or 10 gives mem_type 11 with shareable 0 and policies 00.
- R9: TEX=010 with C,B=00 gives device memory that is not shareable. Every other TEX=010 combination, and every TEX=011 combination, gives mem_type 11 with shareable 0 and policies 00.
- R10: TEX=1xx gives normal memory with outer policy = TEX[1:0], inner policy = {C,B} and shareable=S.
- R11: The AP rights code sets what a hit may do. 000 and 100 allow nothing. 001 allows privileged read and write only. 010 allows privileged read/write and unprivileged read. 011 allows read and write to all. 101 allows privileged read only. 110 and 111 allow read only to all. A disallowed access faults.
- R12: An instruction fetch counts as a read whatever acc_write holds. A fetch that hits a region with XN set faults.
- R13: An access that hits no enabled region reports hit=0, hit_region=0, mem_type=10, shareable=0 and policies 00. It faults unless it is privileged and the fallback enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 00 control, 01 base, 10 size/enable, 11 attributes |
| cfg_wdata | input | 32 | Register write data |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_fetch | input | 1 | Access is an instruction fetch |
| hit | output | 1 | An enabled region matched |
| hit_region | output | 3 | Winning region number, 0 on a miss |
| mem_type | output | 2 | Decoded memory type |
| shareable | output | 1 | Decoded shareability |
| inner_pol | output | 2 | Inner cache policy code |
| outer_pol | output | 2 | Outer cache policy code |
| fault | output | 1 | Permission fault |

## Verification
Addresses are placed just inside and just outside the edges of 32-byte, 1 KB, 1 MB and whole-space regions. These separate a correct mask width from a mask that is one bit off, and they show that size codes below the minimum are raised to it. Nested and overlapping regions are tried with the outer one enabled and then disabled. This separates highest-number priority from lowest-number priority, and shows that enable gating applies both to the winner and to the losers. All 64 combinations of TEX, C, B and S are swept on one region, which tells apart each memory-type row and shows where S is ignored. A second sweep pairs all eight rights codes and both XN values with every mix of privilege, write and fetch. Misses are tried with the fallback off and on.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   localparam int SIZE_W   = 5;
   localparam int MIN_SIZE = 4;
   localparam int LOW_BITS = MIN_SIZE + 1;
   localparam int ATTR_W   = 10;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_BASE = 2'd1;
   localparam logic [1:0] SEL_SIZE = 2'd2;
   localparam logic [1:0] SEL_ATTR = 2'd3;

   localparam logic [1:0] MT_STRONG = 2'b00;
   localparam logic [1:0] MT_DEVICE = 2'b01;
   localparam logic [1:0] MT_NORMAL = 2'b10;
   localparam logic [1:0] MT_UNSUP  = 2'b11;

   localparam logic [1:0] POL_NC   = 2'b00;
   localparam logic [1:0] POL_WBRA = 2'b01;
   localparam logic [1:0] POL_WT   = 2'b10;
   localparam logic [1:0] POL_WB   = 2'b11;

   typedef struct packed {
      logic       xn;
      logic [2:0] ap;
      logic [2:0] tex;
      logic       s;
      logic       c;
      logic       b;
   } rgn_attr_t;

endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
   import mpu_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   localparam int REGN_W     = $clog2(NUM_REGIONS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_wr,
   input  logic [1:0]                         cfg_sel,
   input  logic [31:0]                        cfg_wdata,
   input  logic [ADDR_W-1:0]                  acc_addr,
   output logic [NUM_REGIONS-1:0]             match_vec,
   output rgn_attr_t [NUM_REGIONS-1:0]        attr_arr,
   output logic                               dflt_en
);

   logic [REGN_W-1:0] cur_rgn;
   logic              unused_wdata;

   assign unused_wdata = ^cfg_wdata[30:ATTR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rgn <= '0;
         dflt_en <= 1'b0;
      end else if (cfg_wr && cfg_sel == SEL_CTRL) begin
         cur_rgn <= cfg_wdata[REGN_W-1:0];
         dflt_en <= cfg_wdata[31];
      end
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      logic [ADDR_W-1:0] base_q;
      logic [SIZE_W-1:0] size_q;
      logic              en_q;
      rgn_attr_t         attr_q;
      logic              sel_me;
      logic [5:0]        span;
      logic [ADDR_W-1:0] keep;

      assign sel_me = cfg_wr && (cur_rgn == REGN_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            en_q   <= 1'b0;
            attr_q <= '0;
         end else if (sel_me) begin
            case (cfg_sel)
               SEL_BASE: base_q <= {cfg_wdata[ADDR_W-1:LOW_BITS], LOW_BITS'(0)};
               SEL_SIZE: begin
                  en_q   <= cfg_wdata[0];
                  size_q <= cfg_wdata[SIZE_W:1];
               end
               SEL_ATTR: attr_q <= rgn_attr_t'(cfg_wdata[ATTR_W-1:0]);
               default: ;
            endcase
         end
      end

      always_comb begin
         span = (size_q < SIZE_W'(MIN_SIZE)) ? 6'(LOW_BITS) : 6'(size_q) + 6'd1;
         keep = (int'(span) >= ADDR_W) ? '0 : ({ADDR_W{1'b1}} << span);
      end

      assign match_vec[g] = en_q && (((acc_addr ^ base_q) & keep) == '0);
      assign attr_arr[g]  = attr_q;
   end

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
   parameter int NUM_REGIONS = 8,
   localparam int REGN_W     = $clog2(NUM_REGIONS)
) (
   input  logic [NUM_REGIONS-1:0] match_vec,
   output logic                   hit,
   output logic [REGN_W-1:0]      idx
);

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (match_vec[i]) begin
            hit = 1'b1;
            idx = REGN_W'(i);
         end
      end
   end

endmodule

// File: rtl/mpu_attr_decode.sv
module mpu_attr_decode
   import mpu_pkg::*;
(
   input  rgn_attr_t   attr,
   output logic [1:0]  mem_type,
   output logic        shareable,
   output logic [1:0]  inner_pol,
   output logic [1:0]  outer_pol
);

   always_comb begin
      mem_type  = MT_UNSUP;
      shareable = 1'b0;
      inner_pol = POL_NC;
      outer_pol = POL_NC;
      if (attr.tex[2]) begin
         mem_type  = MT_NORMAL;
         shareable = attr.s;
         outer_pol = attr.tex[1:0];
         inner_pol = {attr.c, attr.b};
      end else begin
         case (attr.tex[1:0])
            2'b00: begin
               if (!attr.c) begin
                  mem_type  = attr.b ? MT_DEVICE : MT_STRONG;
                  shareable = 1'b1;
               end else begin
                  mem_type  = MT_NORMAL;
                  shareable = attr.s;
                  inner_pol = attr.b ? POL_WB : POL_WT;
                  outer_pol = attr.b ? POL_WB : POL_WT;
               end
            end
            2'b01: begin
               if ({attr.c, attr.b} == 2'b00) begin
                  mem_type  = MT_NORMAL;
                  shareable = attr.s;
               end else if ({attr.c, attr.b} == 2'b11) begin
                  mem_type  = MT_NORMAL;
                  shareable = attr.s;
                  inner_pol = POL_WBRA;
                  outer_pol = POL_WBRA;
               end
            end
            2'b10: begin
               if ({attr.c, attr.b} == 2'b00) mem_type = MT_DEVICE;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check (
   input  logic       hit,
   input  logic [2:0] ap,
   input  logic       xn,
   input  logic       dflt_en,
   input  logic       acc_write,
   input  logic       acc_priv,
   input  logic       acc_fetch,
   output logic       fault
);

   logic rd_ok;
   logic wr_ok;
   logic is_wr;

   always_comb begin
      rd_ok = 1'b0;
      wr_ok = 1'b0;
      case (ap)
         3'b001: begin rd_ok = acc_priv; wr_ok = acc_priv; end
         3'b010: begin rd_ok = 1'b1;     wr_ok = acc_priv; end
         3'b011: begin rd_ok = 1'b1;     wr_ok = 1'b1;     end
         3'b101: rd_ok = acc_priv;
         3'b110,
         3'b111: rd_ok = 1'b1;
         default: ;
      endcase
   end

   assign is_wr = acc_write && !acc_fetch;
   assign fault = hit ? ((is_wr ? !wr_ok : !rd_ok) || (acc_fetch && xn))
                      : !(acc_priv && dflt_en);

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
   import mpu_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   localparam int REGN_W     = $clog2(NUM_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_priv,
   input  logic              acc_fetch,
   output logic              hit,
   output logic [REGN_W-1:0] hit_region,
   output logic [1:0]        mem_type,
   output logic              shareable,
   output logic [1:0]        inner_pol,
   output logic [1:0]        outer_pol,
   output logic              fault
);

   if (NUM_REGIONS < 2 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("NUM_REGIONS must lie in 2..16");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end

   logic [NUM_REGIONS-1:0]      match_vec;
   rgn_attr_t [NUM_REGIONS-1:0] attr_arr;
   rgn_attr_t                   sel_attr;
   logic                        dflt_en;
   logic [1:0]                  dec_type;
   logic                        dec_share;
   logic [1:0]                  dec_inner;
   logic [1:0]                  dec_outer;

   mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .match_vec(match_vec),
      .attr_arr(attr_arr), .dflt_en(dflt_en)
   );

   mpu_prio_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
      .match_vec(match_vec), .hit(hit), .idx(hit_region)
   );

   assign sel_attr = attr_arr[hit_region];

   mpu_attr_decode u_dec (
      .attr(sel_attr), .mem_type(dec_type), .shareable(dec_share),
      .inner_pol(dec_inner), .outer_pol(dec_outer)
   );

   mpu_perm_check u_perm (
      .hit(hit), .ap(sel_attr.ap), .xn(sel_attr.xn), .dflt_en(dflt_en),
      .acc_write(acc_write), .acc_priv(acc_priv), .acc_fetch(acc_fetch),
      .fault(fault)
   );

   assign mem_type  = hit ? dec_type  : MT_NORMAL;
   assign shareable = hit ? dec_share : 1'b0;
   assign inner_pol = hit ? dec_inner : POL_NC;
   assign outer_pol = hit ? dec_outer : POL_NC;

endmodule

// File: rtl/mpu_region_match_chk.sv
module mpu_region_match_chk
   import mpu_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   localparam int REGN_W     = $clog2(NUM_REGIONS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_priv,
   input logic                   acc_fetch,
   input logic [NUM_REGIONS-1:0] match_vec,
   input rgn_attr_t              sel_attr,
   input logic                   dflt_en,
   input logic                   hit,
   input logic [REGN_W-1:0]      hit_region,
   input logic [1:0]             mem_type,
   input logic                   shareable,
   input logic [1:0]             inner_pol,
   input logic [1:0]             outer_pol,
   input logic                   fault
);

   AST_PRIO_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((match_vec >> hit_region) == NUM_REGIONS'(1))); // R5

   AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (match_vec == '0)); // R5

   AST_STRONG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mem_type == MT_STRONG) |-> shareable); // R6

   AST_UNSUP_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_type == MT_UNSUP) |-> (!shareable && inner_pol == POL_NC && outer_pol == POL_NC)); // R8

   AST_TEX_HIGH_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel_attr.tex[2]) |-> (mem_type == MT_NORMAL && outer_pol == sel_attr.tex[1:0])); // R10

   AST_NO_ACCESS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel_attr.ap[1:0] == 2'b00) |-> fault); // R11

   AST_XN_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && acc_fetch && sel_attr.xn) |-> fault); // R12

   AST_MISS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !(acc_priv && dflt_en)) |-> fault); // R13

endmodule

bind mpu_region_match mpu_region_match_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_priv(acc_priv), .acc_fetch(acc_fetch),
   .match_vec(match_vec), .sel_attr(sel_attr), .dflt_en(dflt_en),
   .hit(hit), .hit_region(hit_region), .mem_type(mem_type),
   .shareable(shareable), .inner_pol(inner_pol), .outer_pol(outer_pol),
   .fault(fault)
);

// File: tb/mpu_region_match_bench.sv
`timescale 1ns/100ps
module mpu_region_match_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_priv = 1'b1;
   logic        acc_fetch = 1'b0;
   logic        hit;
   logic [2:0]  hit_region;
   logic [1:0]  mem_type;
   logic        shareable;
   logic [1:0]  inner_pol;
   logic [1:0]  outer_pol;
   logic        fault;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   mpu_region_match u_mpu_region_match (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_priv(acc_priv), .acc_fetch(acc_fetch), .hit(hit),
      .hit_region(hit_region), .mem_type(mem_type), .shareable(shareable),
      .inner_pol(inner_pol), .outer_pol(outer_pol), .fault(fault)
   );

   // reference state
   logic [31:0] m_base [8];
   int          m_size [8];
   bit          m_en   [8];
   logic [9:0]  m_attr [8];
   int          m_rgn;
   bit          m_dflt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < 8; r++) begin
            m_base[r] = 0; m_size[r] = 0; m_en[r] = 0; m_attr[r] = 0;
         end
         m_rgn = 0; m_dflt = 0;
      end else if (cfg_wr) begin
         if (cfg_sel == 2'd0) begin
            m_rgn = int'(cfg_wdata[2:0]);
            m_dflt = cfg_wdata[31];
         end else if (cfg_sel == 2'd1) m_base[m_rgn] = cfg_wdata & 32'hFFFF_FFE0;
         else if (cfg_sel == 2'd2) begin
            m_en[m_rgn] = cfg_wdata[0];
            m_size[m_rgn] = int'(cfg_wdata[5:1]);
         end else m_attr[m_rgn] = cfg_wdata[9:0];
      end
   end

   function automatic logic [11:0] model(input logic [31:0] a, input bit w, input bit p, input bit f);
      bit e_hit = 0; int e_rgn = 0; int mt = 2; bit sh = 0; int pin = 0; int pout = 0; bit flt;
      bit rd = 0; bit wr = 0;
      logic [2:0] tex; bit c; bit b; bit s; int ap; bit xn;
      for (int r = 7; r >= 0; r--) begin
         if (!e_hit && m_en[r]) begin
            int n = ((m_size[r] < 4) ? 4 : m_size[r]) + 1;
            if (n >= 32 || (a >> n) == (m_base[r] >> n)) begin e_hit = 1; e_rgn = r; end
         end
      end
      if (e_hit) begin
         tex = m_attr[e_rgn][5:3]; s = m_attr[e_rgn][2]; c = m_attr[e_rgn][1];
         b = m_attr[e_rgn][0]; ap = int'(m_attr[e_rgn][8:6]); xn = m_attr[e_rgn][9];
         if (tex[2]) begin mt = 2; sh = s; pout = int'(tex[1:0]); pin = c * 2 + b; end
         else if (tex == 0 && !c) begin mt = b ? 1 : 0; sh = 1; end
         else if (tex == 0) begin mt = 2; sh = s; pin = b ? 3 : 2; pout = pin; end
         else if (tex == 1 && !c && !b) begin mt = 2; sh = s; end
         else if (tex == 1 && c && b) begin mt = 2; sh = s; pin = 1; pout = 1; end
         else if (tex == 2 && !c && !b) begin mt = 1; sh = 0; end
         else mt = 3;
         if (ap == 1) begin rd = p; wr = p; end
         else if (ap == 2) begin rd = 1; wr = p; end
         else if (ap == 3) begin rd = 1; wr = 1; end
         else if (ap == 5) rd = p;
         else if (ap >= 6) rd = 1;
         flt = (f && xn) || ((w && !f) ? !wr : !rd);
      end else flt = !(p && m_dflt);
      return {e_hit, 3'(e_rgn), 2'(mt), sh, 2'(pin), 2'(pout), flt};
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [11:0] exp_v, act_v;
         exp_v = model(acc_addr, acc_write, acc_priv, acc_fetch);
         act_v = {hit, hit_region, mem_type, shareable, inner_pol, outer_pol, fault};
         total++;
         if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s addr=%h w=%0b p=%0b f=%0b actual=%h expected=%h",
                     tag, acc_addr, acc_write, acc_priv, acc_fetch, act_v, exp_v);
         end
      end
   end

   task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic step(input logic [31:0] a, input bit w, input bit p, input bit f);
      @(posedge clk); #1;
      acc_addr = a; acc_write = w; acc_priv = p; acc_fetch = f;
   endtask

   function automatic logic [31:0] mk(input bit xn, input int ap, input int tex, input bit s, input bit c, input bit b);
      return {22'd0, xn, 3'(ap), 3'(tex), s, c, b};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R1";
      step(32'h0, 0, 1, 0); step(32'h1234_5678, 1, 0, 0); step(32'hFFFF_FFFF, 0, 1, 1);

      tag = "R4";
      cfg(2'd0, 32'd0); cfg(2'd1, 32'h2000_0000);
      cfg(2'd3, mk(0, 3, 0, 0, 1, 1)); cfg(2'd2, (9 << 1) | 1);
      tag = "R2";
      step(32'h1FFF_FFFF, 0, 1, 0); step(32'h2000_0000, 0, 1, 0);
      step(32'h2000_03FF, 1, 0, 0); step(32'h2000_0400, 0, 1, 0);

      tag = "R4";
      cfg(2'd0, 32'd1); cfg(2'd1, 32'h2000_0000);
      cfg(2'd3, mk(0, 3, 1, 1, 0, 0)); cfg(2'd2, (19 << 1) | 1);
      tag = "R5";
      step(32'h2000_0000, 0, 1, 0); step(32'h2000_03FF, 0, 1, 0);
      tag = "R2";
      step(32'h200F_FFFF, 0, 1, 0); step(32'h2010_0000, 0, 1, 0);
      tag = "R5";
      cfg(2'd2, 19 << 1);
      step(32'h2000_0010, 0, 1, 0); step(32'h2008_0000, 0, 1, 0);
      cfg(2'd0, 32'd3); cfg(2'd1, 32'h2000_0000);
      cfg(2'd3, mk(0, 3, 2, 0, 0, 0)); cfg(2'd2, 31 << 1);
      step(32'h2000_0000, 0, 1, 0); step(32'h7000_0000, 0, 1, 0);

      tag = "R3";
      cfg(2'd0, 32'd2); cfg(2'd1, 32'h4000_0047);
      cfg(2'd3, mk(0, 3, 0, 0, 1, 0)); cfg(2'd2, (1 << 1) | 1);
      step(32'h4000_003F, 0, 1, 0); step(32'h4000_0040, 0, 1, 0);
      step(32'h4000_005F, 0, 1, 0); step(32'h4000_0060, 0, 1, 0);

      cfg(2'd0, 32'd4); cfg(2'd1, 32'h6000_0000); cfg(2'd2, (4 << 1) | 1);
      for (int t = 0; t < 8; t++) begin
         for (int csb = 0; csb < 8; csb++) begin
            if (t == 0) tag = csb[1] ? "R7" : "R6";
            else if (t == 1) tag = "R8";
            else if (t < 4) tag = "R9";
            else tag = "R10";
            cfg(2'd3, mk(0, 3, t, csb[2], csb[1], csb[0]));
            step(32'h6000_0004, 0, 1, 0);
            step(32'h6000_001C, 1, 0, 0);
         end
      end

      for (int xn = 0; xn < 2; xn++) begin
         for (int ap = 0; ap < 8; ap++) begin
            tag = xn ? "R12" : "R11";
            cfg(2'd3, mk(xn[0], ap, 0, 0, 1, 1));
            for (int k = 0; k < 8; k++) step(32'h6000_0010, k[0], k[1], k[2]);
         end
      end

      tag = "R13";
      cfg(2'd0, 32'd5);
      step(32'h9000_0000, 0, 1, 0); step(32'h9000_0000, 0, 0, 0); step(32'h9000_0000, 1, 1, 1);
      cfg(2'd0, 32'h8000_0005);
      step(32'h9000_0000, 0, 1, 0); step(32'h9000_0000, 1, 0, 0);
      step(32'h9000_0000, 1, 1, 0); step(32'h9000_0000, 0, 0, 1);

      tag = "R2";
      cfg(2'd0, 32'h8000_0007);
      cfg(2'd3, mk(0, 2, 1, 0, 0, 0)); cfg(2'd2, (31 << 1) | 1);
      step(32'h0, 0, 1, 0); step(32'hFFFF_FFFF, 0, 0, 0);
      step(32'h9000_0000, 1, 0, 0); step(32'h6000_0000, 1, 1, 0);
      tag = "R5";
      cfg(2'd2, 31 << 1);
      step(32'h6000_0000, 0, 1, 0); step(32'hA000_0000, 0, 0, 0);

      @(posedge clk); #1;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule